// File: doc/BRIEF.md
# Accumulator Readout Formatter

This block turns a 48-bit multiply-accumulate result into a 32-bit word for a general register. A read strobe captures the accumulator value, the mode bits and a 2-bit read form. One clock later the formatted word and a valid flag appear at the outputs. The block has no storage for the accumulator and does no arithmetic on it. It only applies the rounding, width reduction and clamping rules that the mode bits select.

There are four read forms: fractional, raw integer, signed-clamping integer and unsigned-clamping integer. In the fractional form the result is either 16 or 32 bits wide. Rounding is round-half-to-even, at a split point that depends on the result width. The rounded value is then clamped or wrapped to the result width, as the overflow-mode bit selects. The accumulator value is always taken as a two's-complement number, with bit 47 as the sign.

Top module: `acc_readout_fmt`

## Requirements
- R1: While reset is asserted and after its release, `res` is 0 and `res_vld` is 0 until the first strobe.
- R2: A strobe in cycle N sets `res_vld` in cycle N+1 only. `res` changes only in the cycle after a strobe and holds its value otherwise.
- R3: With read form 2'b01 (raw), `res` is accumulator bits 31:0, and no check is made on the upper bits.
- R4: With read form 2'b10 (signed integer), a value in the signed 32-bit range passes through unchanged. A larger value gives 0x7FFFFFFF and a smaller one gives 0x80000000.
- R5: With read form 2'b11 (unsigned integer), bits 31:0 pass when bits 47:32 are all zero. Otherwise the result is 0xFFFFFFFF.
- R6: With read form 2'b00 and `mode_half`=1, the value is accumulator bits 47:24 as a signed number. Bits 23:0 are the remainder. The value is incremented when the remainder is above 0x800000. At exactly 0x800000 it is incremented only if it is odd. The 16-bit result sits in bits 15:0 and bits 31:16 are zero. `mode_rnd` has no effect in this mode.
- R7: With read form 2'b00, `mode_half`=0 and `mode_rnd`=1, the value is the accumulator shifted arithmetically right by 8, rounded the same way with bits 7:0 as the remainder and 0x80 as the tie point.
- R8: With read form 2'b00, `mode_half`=0 and `mode_rnd`=0, the value is the accumulator shifted arithmetically right by 8, with no rounding.
- R9: With `mode_sat`=1, a 16-bit fractional value outside -32768..32767 after rounding gives 0x00007FFF if positive and 0x00008000 if negative.
- R10: With `mode_sat`=1, a 32-bit fractional value outside the signed 32-bit range after rounding gives 0x7FFFFFFF if positive and 0x80000000 if negative.
- R11: With `mode_sat`=0, a fractional value that does not fit keeps only its low 16 or 32 bits.
- R12: `mode_sat` has no effect on the three integer read forms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_stb | input | 1 | Read strobe; captures the formatted word |
| rd_form | input | 2 | Read form: 00 fractional, 01 raw, 10 signed, 11 unsigned |
| acc_val | input | 48 | Accumulator value, two's complement |
| mode_half | input | 1 | Fractional result is 16 bits wide when 1 |
| mode_rnd | input | 1 | Rounding enable for the 32-bit fractional result |
| mode_sat | input | 1 | Overflow mode: clamp when 1, wrap when 0 |
| res | output | 32 | Formatted result |
| res_vld | output | 1 | Result updated in this cycle |

## Verification
Each formatter path is combinational and is sampled by a single output register. A wrong rounding increment or a wrong overflow decision therefore shows up as a wrong `res` in the cycle after the strobe that exposes it. Tie remainders with odd and even values, and carries out of rounding that cross a clamp limit, are the places where a bad increment or a bad fit test shows. A fault in the valid flag or in the hold logic shows up as `res_vld` high, or as `res` moving, in the idle cycle after a read.

// File: rtl/acc_fmt_pkg.sv
package acc_fmt_pkg;

  typedef enum logic [1:0] {
    FORM_FRAC = 2'b00,
    FORM_RAW  = 2'b01,
    FORM_SINT = 2'b10,
    FORM_UINT = 2'b11
  } rd_form_e;

  // Round-half-to-even increment decision
  function automatic logic tie_even_up(input logic above_half,
                                       input logic at_half,
                                       input logic quot_lsb);
    return above_half | (at_half & quot_lsb);
  endfunction

  // Signed limit pattern of a given width selected by sign
  function automatic logic [63:0] signed_limit(input logic neg, input int unsigned w);
    logic [63:0] lim;
    lim = (64'd1 << (w - 1));
    return neg ? lim : (lim - 64'd1);
  endfunction

endpackage

// File: rtl/acc_frac_round.sv
module acc_frac_round #(
  parameter int IN_W  = 48,
  parameter int SHIFT = 24,
  localparam int Q_W  = IN_W - SHIFT + 1
) (
  input  logic [IN_W-1:0] acc,
  input  logic            rnd_en,
  output logic [Q_W-1:0]  quot,
  output logic            rnd_inc
);
  import acc_fmt_pkg::*;

  localparam logic [SHIFT-1:0] HALF_PT = {1'b1, {(SHIFT-1){1'b0}}};

  logic [SHIFT-1:0] rem;
  logic             above, at_half;

  always_comb begin
    rem     = acc[SHIFT-1:0];
    above   = rem > HALF_PT;
    at_half = rem == HALF_PT;
    rnd_inc = rnd_en & tie_even_up(above, at_half, acc[SHIFT]);
    quot    = {acc[IN_W-1], acc[IN_W-1:SHIFT]} + {{(Q_W-1){1'b0}}, rnd_inc};
  end

endmodule

// File: rtl/acc_sat_clamp.sv
module acc_sat_clamp #(
  parameter int IN_W  = 41,
  parameter int OUT_N = 32
) (
  input  logic [IN_W-1:0]  val,
  input  logic             sat_en,
  output logic [OUT_N-1:0] y,
  output logic             ovf
);
  import acc_fmt_pkg::*;

  logic [IN_W-OUT_N:0] top_bits;
  logic [63:0]         lim;

  always_comb begin
    top_bits = val[IN_W-1:OUT_N-1];
    ovf      = ~((&top_bits) | ~(|top_bits));
    lim      = signed_limit(val[IN_W-1], OUT_N);
    y        = (sat_en && ovf) ? lim[OUT_N-1:0] : val[OUT_N-1:0];
  end

endmodule

// File: rtl/acc_readout_fmt.sv
module acc_readout_fmt #(
  parameter int ACC_W      = 48,
  parameter int RES_W      = 32,
  parameter int HALF_W     = 16,
  parameter int HALF_SPLIT = 24,
  parameter int FULL_SPLIT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_stb,
  input  logic [1:0]       rd_form,
  input  logic [ACC_W-1:0] acc_val,
  input  logic             mode_half,
  input  logic             mode_rnd,
  input  logic             mode_sat,
  output logic [RES_W-1:0] res,
  output logic             res_vld
);
  import acc_fmt_pkg::*;

  localparam int HQ_W = ACC_W - HALF_SPLIT + 1;
  localparam int FQ_W = ACC_W - FULL_SPLIT + 1;

  // Named internal events, observed by the bound checker
  logic [HQ_W-1:0]   half_q;
  logic [FQ_W-1:0]   full_q;
  logic              half_inc, full_inc;
  logic              half_ovf, full_ovf, sint_ovf, uint_ovf;
  logic [HALF_W-1:0] half_y;
  logic [RES_W-1:0]  full_y, sint_y, half_word, fmt_next;

  // 16-bit fractional path always rounds
  acc_frac_round #(.IN_W(ACC_W), .SHIFT(HALF_SPLIT)) u_rnd_half (
    .acc(acc_val), .rnd_en(1'b1), .quot(half_q), .rnd_inc(half_inc)
  );

  acc_frac_round #(.IN_W(ACC_W), .SHIFT(FULL_SPLIT)) u_rnd_full (
    .acc(acc_val), .rnd_en(mode_rnd), .quot(full_q), .rnd_inc(full_inc)
  );

  acc_sat_clamp #(.IN_W(HQ_W), .OUT_N(HALF_W)) u_clamp_half (
    .val(half_q), .sat_en(mode_sat), .y(half_y), .ovf(half_ovf)
  );

  acc_sat_clamp #(.IN_W(FQ_W), .OUT_N(RES_W)) u_clamp_full (
    .val(full_q), .sat_en(mode_sat), .y(full_y), .ovf(full_ovf)
  );

  // Signed integer read always clamps, independent of the mode bit
  acc_sat_clamp #(.IN_W(ACC_W), .OUT_N(RES_W)) u_clamp_sint (
    .val(acc_val), .sat_en(1'b1), .y(sint_y), .ovf(sint_ovf)
  );

  always_comb begin
    uint_ovf  = |acc_val[ACC_W-1:RES_W];
    half_word = {{(RES_W-HALF_W){1'b0}}, half_y};
    case (rd_form_e'(rd_form))
      FORM_RAW:  fmt_next = acc_val[RES_W-1:0];
      FORM_SINT: fmt_next = sint_y;
      FORM_UINT: fmt_next = uint_ovf ? {RES_W{1'b1}} : acc_val[RES_W-1:0];
      default:   fmt_next = mode_half ? half_word : full_y;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res     <= '0;
      res_vld <= 1'b0;
    end else begin
      res_vld <= rd_stb;
      if (rd_stb) res <= fmt_next;
    end
  end

endmodule

// File: rtl/acc_readout_fmt_chk.sv
module acc_readout_fmt_chk #(
  parameter int ACC_W  = 48,
  parameter int RES_W  = 32,
  parameter int HALF_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_stb,
  input logic [1:0]       rd_form,
  input logic [ACC_W-1:0] acc_val,
  input logic             mode_half,
  input logic             mode_sat,
  input logic [RES_W-1:0] res,
  input logic             res_vld,
  input logic             half_ovf,
  input logic             full_ovf,
  input logic             sint_ovf,
  input logic             uint_ovf
);

  localparam logic [RES_W-1:0] POS32 = {1'b0, {(RES_W-1){1'b1}}};
  localparam logic [RES_W-1:0] NEG32 = {1'b1, {(RES_W-1){1'b0}}};
  localparam logic [RES_W-1:0] POS16 = {{(RES_W-HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
  localparam logic [RES_W-1:0] NEG16 = {{(RES_W-HALF_W){1'b0}}, 1'b1, {(HALF_W-1){1'b0}}};

  AST_VLD_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> res_vld); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> (!res_vld && $stable(res))); // R2
  AST_RAW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_form == 2'b01) |=> res == $past(acc_val[RES_W-1:0])); // R3
  AST_SINT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_form == 2'b10 && sint_ovf) |=>
      res == ($past(acc_val[ACC_W-1]) ? NEG32 : POS32)); // R4
  AST_UINT_ALLONES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_form == 2'b11 && uint_ovf) |=> res == {RES_W{1'b1}}); // R5
  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_form == 2'b00 && mode_half) |=> res[RES_W-1:HALF_W] == '0); // R6
  AST_HALF_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_form == 2'b00 && mode_half && mode_sat && half_ovf) |=>
      res == ($past(acc_val[ACC_W-1]) ? NEG16 : POS16)); // R9
  AST_FULL_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_form == 2'b00 && !mode_half && mode_sat && full_ovf) |=>
      res == ($past(acc_val[ACC_W-1]) ? NEG32 : POS32)); // R10

endmodule

bind acc_readout_fmt acc_readout_fmt_chk #(.ACC_W(ACC_W), .RES_W(RES_W), .HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_form(rd_form), .acc_val(acc_val),
  .mode_half(mode_half), .mode_sat(mode_sat), .res(res), .res_vld(res_vld),
  .half_ovf(half_ovf), .full_ovf(full_ovf), .sint_ovf(sint_ovf), .uint_ovf(uint_ovf)
);

// File: tb/acc_readout_fmt_test.sv
`timescale 1ns/1ps
module acc_readout_fmt_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_stb = 1'b0;
  logic [1:0]  rd_form = 2'b00;
  logic [47:0] acc_val = '0;
  logic        mode_half = 1'b0, mode_rnd = 1'b0, mode_sat = 1'b0;
  logic [31:0] res;
  logic        res_vld;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  acc_readout_fmt uut (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_form(rd_form), .acc_val(acc_val),
    .mode_half(mode_half), .mode_rnd(mode_rnd), .mode_sat(mode_sat),
    .res(res), .res_vld(res_vld)
  );

  // Reference model written with 64-bit integer arithmetic
  function automatic longint round_even(input longint q, input longint rm, input longint half);
    if (rm > half) return q + 1;
    if (rm == half) return q + (q & 1);
    return q;
  endfunction

  function automatic logic [31:0] model(input logic [47:0] a, input logic [1:0] f,
                                        input logic h, input logic r, input logic s);
    longint v, q;
    longint maxi = 64'sd2147483647;
    longint mini = -64'sd2147483648;
    v = {{16{a[47]}}, a};
    case (f)
      2'b01: return a[31:0];
      2'b10: begin
        if (v > maxi) return 32'h7FFFFFFF;
        if (v < mini) return 32'h80000000;
        return a[31:0];
      end
      2'b11: return (a[47:32] == 16'h0) ? a[31:0] : 32'hFFFFFFFF;
      default: begin
        if (h) begin
          q = round_even(v >>> 24, v & 64'hFFFFFF, 64'h800000);
          if (s && (q > 32767 || q < -32768)) return (q < 0) ? 32'h8000 : 32'h7FFF;
          return 32'(q & 64'hFFFF);
        end
        q = v >>> 8;
        if (r) q = round_even(q, v & 64'hFF, 64'h80);
        if (s && q > maxi) return 32'h7FFFFFFF;
        if (s && q < mini) return 32'h80000000;
        return 32'(q & 64'hFFFFFFFF);
      end
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] f, input logic h, input logic r, input logic s);
    case (f)
      2'b01: return "R3";
      2'b10: return "R4";
      2'b11: return "R5";
      default: return h ? (s ? "R9" : "R6") : (s ? "R10" : (r ? "R7" : "R8"));
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // One strobed read, result check, then an idle cycle with scrambled inputs
  task automatic do_read(input string tag, input logic [47:0] a, input logic [1:0] f,
                         input logic h, input logic r, input logic s);
    logic [31:0] exp;
    exp = model(a, f, h, r, s);
    @(negedge clk);
    acc_val = a; rd_form = f; mode_half = h; mode_rnd = r; mode_sat = s; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    acc_val = {$urandom(), $urandom()} ;
    rd_form = 2'($urandom());
    check(tag, res, exp);
    check("R2", {31'd0, res_vld}, 32'd1);
    @(negedge clk);
    check("R2", {31'd0, res_vld}, 32'd0);
    check("R2", res, exp);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1", res, 32'h0);
    check("R1", {31'd0, res_vld}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {31'd0, res_vld}, 32'd0);

    // R3 raw read ignores upper bits
    do_read("R3", 48'h8000_1234_5678, 2'b01, 0, 0, 1);
    // R4 signed read boundaries
    do_read("R4", 48'hFFFF_FFFF_FFFB, 2'b10, 0, 0, 0);
    do_read("R4", 48'h0000_7FFF_FFFF, 2'b10, 0, 0, 0);
    do_read("R4", 48'h0000_8000_0000, 2'b10, 0, 0, 0);
    do_read("R4", 48'hFFFF_8000_0000, 2'b10, 0, 0, 0);
    do_read("R4", 48'hFFFF_7FFF_FFFF, 2'b10, 0, 0, 1);
    // R5 unsigned read
    do_read("R5", 48'h0000_FFFF_FFFF, 2'b11, 0, 0, 0);
    do_read("R5", 48'h0001_0000_0000, 2'b11, 0, 0, 0);
    do_read("R5", 48'hFFFF_FFFF_FFFF, 2'b11, 0, 0, 1);
    // R12 mode_sat ignored on integer forms
    do_read("R12", 48'h0001_0000_0000, 2'b10, 0, 0, 0);
    do_read("R12", 48'h0001_0000_0000, 2'b10, 0, 0, 1);
    do_read("R12", 48'h0000_8000_0000, 2'b01, 0, 0, 1);
    do_read("R12", 48'h0002_0000_0005, 2'b11, 1, 1, 1);
    // R6 16-bit ties to even, rnd bit ignored
    do_read("R6", 48'h0000_0380_0000, 2'b00, 1, 0, 0);
    do_read("R6", 48'h0000_0280_0000, 2'b00, 1, 1, 0);
    do_read("R6", 48'h0000_0280_0001, 2'b00, 1, 0, 0);
    do_read("R6", 48'hFFFF_FF80_0000, 2'b00, 1, 0, 0);
    // R9 / R11 16-bit clamp and wrap
    do_read("R9",  48'h007F_FF80_0000, 2'b00, 1, 0, 1);
    do_read("R11", 48'h007F_FF80_0000, 2'b00, 1, 0, 0);
    do_read("R9",  48'hFF80_0000_0000, 2'b00, 1, 0, 1);
    do_read("R9",  48'hFF7F_FF00_0000, 2'b00, 1, 0, 1);
    do_read("R11", 48'hFF7F_FF00_0000, 2'b00, 1, 0, 0);
    // R7 32-bit rounding
    do_read("R7", 48'h0000_0000_0180, 2'b00, 0, 1, 0);
    do_read("R7", 48'h0000_0000_0280, 2'b00, 0, 1, 0);
    do_read("R7", 48'h0000_0000_0281, 2'b00, 0, 1, 0);
    do_read("R7", 48'hFFFF_FFFF_FF80, 2'b00, 0, 1, 0);
    // R8 no rounding
    do_read("R8", 48'h0000_0000_02FF, 2'b00, 0, 0, 0);
    do_read("R8", 48'hFFFF_FFFF_FEFF, 2'b00, 0, 0, 0);
    // R10 / R11 32-bit clamp and wrap, incl. carry from rounding
    do_read("R10", 48'h0080_0000_0000, 2'b00, 0, 0, 1);
    do_read("R11", 48'h0080_0000_0000, 2'b00, 0, 0, 0);
    do_read("R10", 48'h007F_FFFF_FF80, 2'b00, 0, 1, 1);
    do_read("R11", 48'h007F_FFFF_FF80, 2'b00, 0, 1, 0);
    do_read("R10", 48'h8000_0000_0000, 2'b00, 0, 0, 1);

    // Constrained random reads
    for (int i = 0; i < 600; i++) begin
      logic [47:0] a;
      logic [1:0]  f;
      logic        h, r, s;
      f = 2'($urandom()); h = 1'($urandom()); r = 1'($urandom()); s = 1'($urandom());
      case ($urandom() % 4)
        0: a = {16'($urandom()), $urandom()};
        1: a = {{16{1'b0}}, $urandom()} ^ {48{1'($urandom())}};
        2: a = {{9{1'($urandom())}}, 39'({$urandom(), $urandom()})};
        default: a = {{17{1'($urandom())}}, 7'($urandom()), 24'h800000 ^ 24'($urandom() % 3)};
      endcase
      do_read(tag_of(f, h, r, s), a, f, h, r, s);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule